// File: doc/BRIEF.md
# Transmit Audio FIFO with Burst Request Control

This block is a sample buffer on the playback path. It sits between a word-writing transfer engine and a serial audio shifter. The engine pushes 32-bit words through a valid/data write port, and the shifter pulls them one at a time through a read port. The block counts how many words it holds and drives a single transfer-request line that tells the engine when to write more.

The request line works in one of two modes. In per-word mode it asks for data whenever at least one slot is free. In burst mode, software programs a burst length minus one, and the request rises only when that many slots are free. It then stays high until that many words have arrived. In both modes, each time the block is enabled it first keeps the request high until the buffer is completely full. The shifter therefore never starts against a half-empty buffer.

A write into a full buffer is dropped and latches an overflow flag. A read from an empty buffer returns zero and latches an underflow flag. Both flags clear only on reset.

Top module: `tx_audio_fifo_req`

## Requirements
- R1: A synchronous active-high reset empties the buffer and drives `level` to 0, `dma_req` to 0, `overflow` and `underflow` to 0, and `rd_data` to 0.
- R2: The buffer holds `DEPTH` (default 1024) words of `DATA_W` (default 32) bits. Words leave in the order they were accepted, and `level` never exceeds `DEPTH`.
- R3: After `enable` is raised, `dma_req` is held at 1 until `level` reaches `DEPTH`, whatever `mode` is. Whenever `level` equals `DEPTH`, `dma_req` is 0.
- R4: Per-word mode (`mode` = 0): once the buffer has been filled after enable, `dma_req` is 1 exactly when `level` < `DEPTH`.
- R5: Burst mode (`mode` = 1): `thresh` holds the burst length minus one. Once the buffer has been filled after enable, `dma_req` rises in the cycle that free space (`DEPTH` − `level`) becomes at least `thresh`+1. It then stays at 1 until `thresh`+1 words have been accepted, even if the buffer has not yet filled. After that burst ends, a new burst starts only when free space again reaches the burst length.
- R6: A write while `level` equals `DEPTH` is dropped, even if a read happens in the same cycle, and `overflow` becomes 1 and stays 1.
- R7: A read while `level` is 0 leaves `level` at 0, makes `rd_data` 0 in the following cycle, and sets `underflow`, which stays 1.
- R8: An accepted write and an accepted read in the same cycle leave `level` unchanged.
- R9: While `enable` is 0, `dma_req` is 0 from the next cycle on. The next time `enable` rises, the fill phase of R3 starts again.
- R10: A read accepted at one clock edge presents the word on `rd_data` after that same edge, and `rd_data` holds that word until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Stream running; a rising value restarts the fill phase |
| mode | input | 1 | 0 = request per word, 1 = request per burst |
| thresh | input | ADDR_W (10) | Burst length minus one |
| wr_valid | input | 1 | Write strobe from the transfer engine |
| wr_data | input | DATA_W (32) | Word to store |
| rd_req | input | 1 | Pull strobe from the shifter |
| rd_data | output | DATA_W (32) | Word read out, or 0 after an empty read |
| level | output | CNT_W (11) | Words currently held |
| dma_req | output | 1 | Transfer request toward the engine |
| overflow | output | 1 | Sticky: a write was dropped at full |
| underflow | output | 1 | Sticky: a read found the buffer empty |

## Verification
The two actions that can fall in the same cycle are a write from the engine and a read from the shifter. The bench issues both strobes together at three levels: mid-buffer, where the level must hold steady and any burst countdown must still advance; exactly full, where the write must be dropped and flagged while the read still drains a word; and during a live burst, where the request must stay high. Each result is judged against a queue model of the buffer and a level counter kept in the bench. The request is predicted from the mode, the burst length and the count of words accepted since the burst began.

// File: rtl/afq_pkg.sv
package afq_pkg;
  typedef enum logic {
    AFQ_PER_WORD = 1'b0,
    AFQ_BURST    = 1'b1
  } afq_mode_e;
endpackage

// File: rtl/afq_store.sv
module afq_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_q
);
  // Plain dual-port array with a registered read port, for block RAM mapping.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/afq_occupancy.sv
module afq_occupancy #(
  parameter int DEPTH = 1024,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic              rd_req,
  output logic              wr_acc,
  output logic              rd_acc,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_nxt,
  output logic              overflow,
  output logic              underflow,
  output logic              rd_zero
);
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DEPTH);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);

  logic is_full, is_empty;

  assign is_full  = (count == FULL_CNT);
  assign is_empty = (count == '0);
  // Acceptance depends on the stored level only; a concurrent read does not
  // open room for a write at full.
  assign wr_acc   = wr_valid && !is_full;
  assign rd_acc   = rd_req && !is_empty;

  always_comb begin
    count_nxt = count;
    if (wr_acc && !rd_acc) count_nxt = count + CNT_W'(1);
    if (rd_acc && !wr_acc) count_nxt = count - CNT_W'(1);
  end

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      rd_zero   <= 1'b1;
    end else begin
      count <= count_nxt;
      if (wr_acc) wr_ptr <= bump(wr_ptr);
      if (rd_acc) rd_ptr <= bump(rd_ptr);
      if (wr_valid && is_full) overflow <= 1'b1;
      if (rd_req && is_empty)  underflow <= 1'b1;
      if (rd_req) rd_zero <= is_empty;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT); // R2
  AST_OVF_DROP: assert property (@(posedge clk) disable iff (rst)
    (is_full && wr_valid && !rd_req) |=> (count == FULL_CNT)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R6
  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (is_empty && rd_req && !wr_valid) |=> (count == '0)); // R7
  AST_BOTH_STEADY: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && rd_acc) |=> $stable(count)); // R8
endmodule

// File: rtl/afq_req_ctrl.sv
module afq_req_ctrl
  import afq_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  afq_mode_e         mode,
  input  logic [ADDR_W-1:0] thresh,
  input  logic              wr_acc,
  input  logic [CNT_W-1:0]  count_nxt,
  output logic              dma_req
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic             filled, filled_nxt;
  logic [CNT_W-1:0] left, left_nxt, left_dec;
  logic [CNT_W-1:0] burst_len, free_nxt;
  logic             req_nxt;

  assign burst_len = CNT_W'(thresh) + CNT_W'(1);
  assign free_nxt  = FULL_CNT - count_nxt;
  assign left_dec  = (left != '0 && wr_acc) ? left - CNT_W'(1) : left;

  always_comb begin
    filled_nxt = enable && (filled || count_nxt == FULL_CNT);
    left_nxt   = '0;
    req_nxt    = 1'b0;
    if (!enable) begin
      req_nxt = 1'b0;
    end else if (!filled_nxt) begin
      req_nxt = 1'b1;              // fill phase: ask until full
    end else if (mode == AFQ_PER_WORD) begin
      req_nxt = (count_nxt != FULL_CNT);
    end else begin
      left_nxt = left_dec;
      if (left_dec == '0 && free_nxt >= burst_len) left_nxt = burst_len;
      req_nxt = (left_nxt != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filled  <= 1'b0;
      left    <= '0;
      dma_req <= 1'b0;
    end else begin
      filled  <= filled_nxt;
      left    <= left_nxt;
      dma_req <= req_nxt;
    end
  end

  AST_REQ_OFF_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !dma_req); // R9
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (enable && !filled && count_nxt != FULL_CNT) |=> dma_req); // R3
endmodule

// File: rtl/tx_audio_fifo_req.sv
module tx_audio_fifo_req
  import afq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              mode,
  input  logic [ADDR_W-1:0] thresh,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  level,
  output logic              dma_req,
  output logic              overflow,
  output logic              underflow
);
  logic              wr_acc, rd_acc, rd_zero;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count_nxt;
  logic [DATA_W-1:0] ram_q;

  afq_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .rd_req(rd_req),
    .wr_acc(wr_acc), .rd_acc(rd_acc), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(level), .count_nxt(count_nxt), .overflow(overflow),
    .underflow(underflow), .rd_zero(rd_zero)
  );

  afq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_acc), .wr_addr(wr_ptr), .wr_data(wr_data),
    .rd_en(rd_acc), .rd_addr(rd_ptr), .rd_q(ram_q)
  );

  afq_req_ctrl #(.DEPTH(DEPTH)) u_req (
    .clk(clk), .rst(rst), .enable(enable), .mode(afq_mode_e'(mode)),
    .thresh(thresh), .wr_acc(wr_acc), .count_nxt(count_nxt),
    .dma_req(dma_req)
  );

  // RAM output carries no reset, so an empty or post-reset read is masked.
  assign rd_data = rd_zero ? '0 : ram_q;

  AST_UNF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (level == '0 && rd_req) |=> (rd_data == '0)); // R7
  AST_FULL_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (level == CNT_W'(DEPTH)) |-> !dma_req); // R3
endmodule

// File: tb/tb_tx_audio_fifo_req.sv
module tb_tx_audio_fifo_req;
  localparam int DW = 32;
  localparam int DP = 1024;
  localparam int AW = $clog2(DP);
  localparam int CW = $clog2(DP + 1);

  logic          clk = 1'b0;
  logic          rst, enable, mode, wr_valid, rd_req;
  logic [AW-1:0] thresh;
  logic [DW-1:0] wr_data, rd_data;
  logic [CW-1:0] level;
  logic          dma_req, overflow, underflow;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [DW-1:0] model[$];
  int            mlevel = 0;
  logic [DW-1:0] wcnt = 32'h1000_0000;

  always #10 clk = ~clk;  // 50 MHz

  tx_audio_fifo_req #(.DATA_W(DW), .DEPTH(DP)) dut (
    .clk(clk), .rst(rst), .enable(enable), .mode(mode), .thresh(thresh),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .rd_data(rd_data), .level(level), .dma_req(dma_req),
    .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle: inputs applied after a falling edge, results sampled at the next.
  task automatic cyc(input bit w, input bit r);
    logic [DW-1:0] exp_rd;
    bit did_rd;
    wr_valid = w; rd_req = r; wr_data = wcnt;
    did_rd = r && (mlevel > 0);
    exp_rd = did_rd ? model[0] : '0;
    @(negedge clk);
    wr_valid = 0; rd_req = 0;
    if (did_rd) void'(model.pop_front());
    if (w && mlevel < DP) begin model.push_back(wcnt); wcnt++; end
    mlevel = model.size();
    if (r) chk(rd_data == exp_rd, "R10 read data", rd_data, exp_rd);
  endtask

  // {wr, rd, expected req, expected level}
  localparam logic [13:0] VEC [16] = '{
    {1'b0, 1'b1, 1'b0, 11'd1023}, {1'b0, 1'b1, 1'b0, 11'd1022},
    {1'b0, 1'b1, 1'b0, 11'd1021}, {1'b0, 1'b1, 1'b1, 11'd1020},
    {1'b1, 1'b1, 1'b1, 11'd1020}, {1'b1, 1'b0, 1'b1, 11'd1021},
    {1'b1, 1'b0, 1'b1, 11'd1022}, {1'b1, 1'b0, 1'b0, 11'd1023},
    {1'b0, 1'b1, 1'b0, 11'd1022}, {1'b0, 1'b1, 1'b0, 11'd1021},
    {1'b0, 1'b1, 1'b1, 11'd1020}, {1'b0, 1'b1, 1'b1, 11'd1019},
    {1'b1, 1'b0, 1'b1, 11'd1020}, {1'b1, 1'b0, 1'b1, 11'd1021},
    {1'b1, 1'b0, 1'b1, 11'd1022}, {1'b1, 1'b0, 1'b0, 11'd1023}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; enable = 0; mode = 0; thresh = '0; wr_valid = 0; rd_req = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(level == 0, "R1 level", level, 0);
    chk(dma_req == 0, "R1 req", dma_req, 0);
    chk(overflow == 0 && underflow == 0, "R1 flags", {overflow, underflow}, 0);
    chk(rd_data == 0, "R1 rd_data", rd_data, 0);
    // R9 disabled: no request
    @(negedge clk);
    chk(dma_req == 0, "R9 req while disabled", dma_req, 0);

    // R3 fill phase in burst mode
    mode = 1; thresh = 10'd3; enable = 1;
    @(negedge clk);
    chk(dma_req == 1, "R3 req after enable", dma_req, 1);
    for (int i = 0; i < 500; i++) cyc(1, 0);
    chk(dma_req == 1, "R3 req held mid fill", dma_req, 1);
    chk(level == 500, "R2 level mid fill", level, 500);
    for (int i = 500; i < DP; i++) cyc(1, 0);
    chk(level == DP, "R2 full level", level, DP);
    chk(dma_req == 0, "R3 req drops at full", dma_req, 0);

    // R5 / R8 burst-mode table
    for (int i = 0; i < 16; i++) begin
      cyc(VEC[i][13], VEC[i][12]);
      chk(dma_req == VEC[i][11], $sformatf("R5 vec %0d req", i), dma_req, VEC[i][11]);
      chk(level == VEC[i][10:0], $sformatf("R8 vec %0d level", i), level, VEC[i][10:0]);
    end

    // R4 per-word mode
    mode = 0;
    @(negedge clk);
    chk(dma_req == 1, "R4 req with one free slot", dma_req, 1);
    cyc(1, 0);
    chk(dma_req == 0, "R4 req off at full", dma_req, 0);
    cyc(0, 1);
    chk(dma_req == 1, "R4 req after one read", dma_req, 1);
    cyc(1, 0);
    chk(dma_req == 0, "R4 req off again", dma_req, 0);

    // R6 overflow, alone and with a concurrent read
    cyc(1, 0);
    chk(level == DP, "R6 level after dropped write", level, DP);
    chk(overflow == 1, "R6 overflow set", overflow, 1);
    cyc(1, 1);
    chk(level == DP - 1, "R6 write dropped with read", level, DP - 1);

    // R9 disable then re-enable restarts the fill phase
    enable = 0; mode = 1;
    @(negedge clk);
    chk(dma_req == 0, "R9 req off when disabled", dma_req, 0);
    enable = 1;
    @(negedge clk);
    chk(dma_req == 1, "R9 fill restarts", dma_req, 1);
    cyc(1, 0);
    chk(dma_req == 0, "R3 refill done", dma_req, 0);

    // Drain, then R7 underflow
    for (int i = 0; i < DP; i++) cyc(0, 1);
    chk(level == 0, "R2 drained", level, 0);
    chk(underflow == 0, "R7 no underflow yet", underflow, 0);
    cyc(0, 1);
    chk(rd_data == 0, "R7 empty read data", rd_data, 0);
    chk(level == 0, "R7 level stays 0", level, 0);
    chk(underflow == 1, "R7 underflow set", underflow, 1);
    chk(overflow == 1, "R6 overflow sticky", overflow, 1);

    // R1 reset clears the flags
    rst = 1;
    @(negedge clk);
    rst = 0; model.delete(); mlevel = 0;
    @(negedge clk);
    chk(overflow == 0 && underflow == 0, "R1 flags cleared", {overflow, underflow}, 0);
    chk(level == 0 && dma_req == 1, "R1 empty, fill restarted", {level, dma_req}, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule